// File: doc/BRIEF.md
# Flash Read-Path Status and Identification Multiplexer

This block sits on the byte-wide read path of a page-programmed flash device. On every clock it decides what a host read returns. Outside an internal program or erase cycle it returns the array data. During such a cycle it returns a status byte that software can poll. While identification mode is active it returns fixed vendor and device codes. It also produces the enable for the tri-state data pins, so the pins are driven only while the host holds both the select and the output-enable strobes low.

The status byte has two polled bits. The polarity bit is the inverse of the top bit of the byte loaded last, so software sees the true value once the cycle ends. The toggle bit changes on every new read access while the cycle is running. A read access is one low-going edge of the combined select-and-output-enable condition. A read that is held over many clocks therefore keeps one toggle value. The command decoder and page buffer supply the busy flag, the identification flag and the polled bit. Every output is registered and follows its inputs by one clock.

Top module: `flash_rd_mux`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rd_drive` is 0 and `rd_data` is 8'h00. The toggle state is cleared.
- R2: `rd_drive` is 1 in the cycle after both `sel_n` and `out_en_n` were sampled low, and 0 otherwise. When `rd_drive` is 0, `rd_data` is 8'h00.
- R3: For a read with `busy` low and `id_mode` low, `rd_data` equals the `arr_data` sampled with it.
- R4: For a read with `busy` high, bit 7 of `rd_data` is the inverse of the sampled `last_poll_bit`.
- R5: For a read with `busy` high, bits 5 to 0 of `rd_data` are 0.
- R6: While `busy` stays high, bit 6 of `rd_data` inverts at each new read access (combined strobe going low). It does not change while one access is held.
- R7: A rising edge of `busy` clears the toggle state. The first read access of a new cycle therefore returns bit 6 = 1, and this holds even when that access starts in the same cycle as the rise.
- R8: For a read with `busy` low and `id_mode` high, address 17'h00000 returns 8'hDA and 17'h00001 returns 8'hC1. Any address with a nonzero bit in [16:1] returns 8'h00.
- R9: `busy` takes priority over `id_mode`, so a busy read returns the status byte of R4 to R6.
- R10: Once `busy` returns low, a read returns the array data again, with bit 7 true rather than inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Device select, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address of the read |
| busy | input | 1 | Internal program or erase cycle in progress |
| last_poll_bit | input | 1 | Bit 7 of the byte loaded last |
| id_mode | input | 1 | Identification mode active |
| arr_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Registered read data |
| rd_drive | output | 1 | Registered enable for the tri-state data pins |

## Verification
Two events can fall in the same clock: the start of a new programming cycle (`busy` rising) and the start of a read access. The first clears the toggle state and the second inverts it. The bench provokes this directly by raising `busy` in the same cycle as the strobes go low. It also reaches the case through random strobes and random `busy` edges. A bench model updates clear-then-invert in that order, so the expected bit 6 for such a read is 1, and each read's bit 6 is compared against the model.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_IDENT  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/frm_access_detect.sv
module frm_access_detect (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic out_en_n,
  input  logic busy,
  output logic rd_act,
  output logic rd_start,
  output logic prog_start
);
  logic act_q;
  logic busy_q;

  assign rd_act     = !sel_n && !out_en_n;
  assign rd_start   = rd_act && !act_q;
  assign prog_start = busy && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      act_q  <= rd_act;
      busy_q <= busy;
    end
  end
endmodule

// File: rtl/frm_toggle_track.sv
module frm_toggle_track (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_start,
  input  logic prog_start,
  output logic tgl_now
);
  logic tgl_q;
  logic tgl_base;

  // A new cycle clears first, then a read start in the same cycle inverts.
  always_comb begin
    tgl_base = prog_start ? 1'b0 : tgl_q;
    tgl_now  = (busy && rd_start) ? !tgl_base : tgl_base;
  end

  always_ff @(posedge clk) begin
    if (rst) tgl_q <= 1'b0;
    else     tgl_q <= tgl_now;
  end
endmodule

// File: rtl/frm_id_decode.sv
module frm_id_decode #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'hDA,
  parameter logic [7:0]  DEV_CODE = 8'hC1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] id_byte
);
  localparam int UPPER_W = ADDR_W - 1;

  logic upper_zero;
  assign upper_zero = (addr[ADDR_W-1:1] == {UPPER_W{1'b0}});

  always_comb begin
    id_byte = '0;
    if (upper_zero) begin
      if (addr[0]) id_byte = DATA_W'(DEV_CODE);
      else         id_byte = DATA_W'(MFR_CODE);
    end
  end
endmodule

// File: rtl/frm_out_stage.sv
module frm_out_stage
  import flash_rd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_act,
  input  logic              busy,
  input  logic              id_mode,
  input  logic              last_poll_bit,
  input  logic              tgl_now,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [DATA_W-1:0] id_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  rd_src_e           src;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] data_nxt;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_stat
      if (i == POLL_BIT) begin : g_poll
        assign status_byte[i] = !last_poll_bit;
      end else if (i == TGL_BIT) begin : g_tgl
        assign status_byte[i] = tgl_now;
      end else begin : g_zero
        assign status_byte[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (!rd_act)      src = SRC_IDLE;
    else if (busy)    src = SRC_STATUS;
    else if (id_mode) src = SRC_IDENT;
    else              src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY:  data_nxt = arr_data;
      SRC_STATUS: data_nxt = status_byte;
      SRC_IDENT:  data_nxt = id_byte;
      default:    data_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= data_nxt;
      rd_drive <= rd_act;
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter int          POLL_BIT = 7,
  parameter int          TGL_BIT  = 6,
  parameter logic [7:0]  MFR_CODE = 8'hDA,
  parameter logic [7:0]  DEV_CODE = 8'hC1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              last_poll_bit,
  input  logic              id_mode,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic              rd_act;
  logic              rd_start;
  logic              prog_start;
  logic              tgl_now;
  logic [DATA_W-1:0] id_byte;

  frm_access_detect u_det (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .out_en_n   (out_en_n),
    .busy       (busy),
    .rd_act     (rd_act),
    .rd_start   (rd_start),
    .prog_start (prog_start)
  );

  frm_toggle_track u_tgl (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rd_start   (rd_start),
    .prog_start (prog_start),
    .tgl_now    (tgl_now)
  );

  frm_id_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_id (
    .addr    (addr),
    .id_byte (id_byte)
  );

  frm_out_stage #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .rd_act        (rd_act),
    .busy          (busy),
    .id_mode       (id_mode),
    .last_poll_bit (last_poll_bit),
    .tgl_now       (tgl_now),
    .arr_data      (arr_data),
    .id_byte       (id_byte),
    .rd_data       (rd_data),
    .rd_drive      (rd_drive)
  );
endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter int          POLL_BIT = 7,
  parameter int          TGL_BIT  = 6,
  parameter logic [7:0]  MFR_CODE = 8'hDA
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              last_poll_bit,
  input logic              id_mode,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);
  logic act;
  assign act = !sel_n && !out_en_n;

  // R2
  drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    act |=> rd_drive);

  // R2
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!rd_drive && rd_data == '0));

  // R3
  array_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && !id_mode) |=> rd_data == $past(arr_data));

  // R4
  poll_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (act && busy) |=> rd_data[POLL_BIT] == !$past(last_poll_bit));

  // R5
  status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act && busy) |=> (rd_data & ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TGL_BIT))) == '0);

  // R6
  held_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && busy && $past(busy) && !$past(rst))
      |=> rd_data[TGL_BIT] == $past(rd_data[TGL_BIT]));

  // R8
  id_mfr_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && id_mode && addr == '0) |=> rd_data == DATA_W'(MFR_CODE));
endmodule

bind flash_rd_mux frm_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT),
  .TGL_BIT  (TGL_BIT),
  .MFR_CODE (MFR_CODE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sel_n         (sel_n),
  .out_en_n      (out_en_n),
  .addr          (addr),
  .busy          (busy),
  .last_poll_bit (last_poll_bit),
  .id_mode       (id_mode),
  .arr_data      (arr_data),
  .rd_data       (rd_data),
  .rd_drive      (rd_drive)
);

// File: tb/sim_flash_rd_mux.sv
module sim_flash_rd_mux;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1;
  logic          out_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          busy = 1'b0;
  logic          last_poll_bit = 1'b0;
  logic          id_mode = 1'b0;
  logic [7:0]    arr_data = 8'h00;
  logic [7:0]    rd_data;
  logic          rd_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  bit m_act = 1'b0;
  bit m_busy = 1'b0;
  bit m_tgl = 1'b0;

  flash_rd_mux u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .out_en_n(out_en_n), .addr(addr),
    .busy(busy), .last_poll_bit(last_poll_bit), .id_mode(id_mode),
    .arr_data(arr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_byte(bit act, bit b, bit im, logic [AW-1:0] a,
                                          bit lb, logic [7:0] ad, bit t);
    if (!act) return 8'h00;
    if (b) return {~lb, t, 6'b0};
    if (im) begin
      if (a == 17'h00000) return 8'hDA;
      if (a == 17'h00001) return 8'hC1;
      return 8'h00;
    end
    return ad;
  endfunction

  function automatic string auto_tag(bit act, bit b, bit im);
    if (!act) return "R2";
    if (b) return "R4";
    if (im) return "R8";
    return "R3";
  endfunction

  task automatic check(input string tag, input bit drv, input logic [7:0] dat,
                       input bit edrv, input logic [7:0] edat);
    checks++;
    if (drv !== edrv || dat !== edat) begin
      failures++;
      $display("FAIL %s: rd_drive=%0b rd_data=%02h expected rd_drive=%0b rd_data=%02h",
               tag, drv, dat, edrv, edat);
    end
  endtask

  task automatic step(input bit c, input bit o, input logic [AW-1:0] a, input bit b,
                      input bit lb, input bit im, input logic [7:0] ad, input string tag);
    bit act, rs, ps, base, nx;
    logic [7:0] e;
    @(negedge clk);
    sel_n = c; out_en_n = o; addr = a; busy = b;
    last_poll_bit = lb; id_mode = im; arr_data = ad;
    act = !c && !o;
    rs = act && !m_act;
    ps = b && !m_busy;
    base = ps ? 1'b0 : m_tgl;
    nx = (b && rs) ? ~base : base;
    e = exp_byte(act, b, im, a, lb, ad, nx);
    m_act = act; m_busy = b; m_tgl = nx;
    @(posedge clk); #1;
    check(tag == "" ? auto_tag(act, b, im) : tag, rd_drive, rd_data, act, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, with a read requested during reset
    sel_n = 1'b0; out_en_n = 1'b0; arr_data = 8'h5A;
    repeat (3) @(posedge clk);
    #1 check("R1", rd_drive, rd_data, 1'b0, 8'h00);
    @(negedge clk);
    rst = 1'b0; sel_n = 1'b1; out_en_n = 1'b1;
    m_act = 1'b0; m_busy = 1'b0; m_tgl = 1'b0;
    #1 check("R1", rd_drive, rd_data, 1'b0, 8'h00);

    // R2: one strobe low is not a read
    step(1'b0, 1'b1, 17'h0, 1'b0, 1'b0, 1'b0, 8'h33, "R2");
    step(1'b1, 1'b0, 17'h0, 1'b0, 1'b0, 1'b0, 8'h33, "R2");
    // R3: array data
    step(1'b0, 1'b0, 17'h123, 1'b0, 1'b0, 1'b0, 8'hA5, "R3");
    step(1'b0, 1'b0, 17'h124, 1'b0, 1'b0, 1'b0, 8'h3C, "R3");
    step(1'b1, 1'b1, 17'h0, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    // R7: busy rises with a read start in the same cycle -> bit6 = 1
    step(1'b0, 1'b0, 17'h40, 1'b1, 1'b1, 1'b0, 8'hFF, "R7");
    // R6: held read keeps bit6; R4/R5 polarity and zero bits
    step(1'b0, 1'b0, 17'h40, 1'b1, 1'b1, 1'b0, 8'hFF, "R6");
    step(1'b0, 1'b0, 17'h41, 1'b1, 1'b0, 1'b0, 8'hFF, "R4");
    step(1'b1, 1'b1, 17'h41, 1'b1, 1'b0, 1'b0, 8'hFF, "R2");
    step(1'b0, 1'b0, 17'h41, 1'b1, 1'b0, 1'b0, 8'hFF, "R6");
    step(1'b0, 1'b1, 17'h41, 1'b1, 1'b0, 1'b0, 8'hFF, "R2");
    step(1'b0, 1'b0, 17'h41, 1'b1, 1'b0, 1'b0, 8'h00, "R5");
    // R9: busy outranks ID mode
    step(1'b1, 1'b0, 17'h0, 1'b1, 1'b1, 1'b1, 8'h00, "R2");
    step(1'b0, 1'b0, 17'h0, 1'b1, 1'b1, 1'b1, 8'h00, "R9");
    // R10: busy clears, held read now returns true array data
    step(1'b0, 1'b0, 17'h41, 1'b0, 1'b1, 1'b0, 8'h80, "R10");
    step(1'b1, 1'b1, 17'h41, 1'b0, 1'b1, 1'b0, 8'h80, "R2");
    // R7: new cycle without a read, then first read shows bit6 = 1
    step(1'b1, 1'b1, 17'h41, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
    step(1'b0, 1'b0, 17'h41, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
    step(1'b1, 1'b1, 17'h41, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    // R8: identification codes
    step(1'b0, 1'b0, 17'h00000, 1'b0, 1'b0, 1'b1, 8'h11, "R8");
    step(1'b0, 1'b0, 17'h00001, 1'b0, 1'b0, 1'b1, 8'h11, "R8");
    step(1'b0, 1'b0, 17'h00002, 1'b0, 1'b0, 1'b1, 8'h11, "R8");
    step(1'b0, 1'b0, 17'h10001, 1'b0, 1'b0, 1'b1, 8'h11, "R8");

    // random phase, expected values from the bench model
    for (int i = 0; i < 4000; i++) begin
      bit c, o, b, lb, im;
      logic [AW-1:0] a;
      c  = ($urandom % 5) == 0;
      o  = ($urandom % 4) == 0;
      b  = (($urandom % 16) == 0) ? ~busy : busy;
      lb = $urandom % 2;
      im = ($urandom % 3) == 0;
      a  = (($urandom % 2) == 0) ? AW'($urandom % 3) : AW'($urandom);
      step(c, o, a, b, lb, im, 8'($urandom), "");
    end

    finish_run();
  end
endmodule